// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time Interlock

This block turns a pulse-width input and a direction input into four gate-enable signals for a full H-bridge of power switches: a high and a low switch on each of two half-bridges (legs). While the pulse input is low, both high switches conduct, so both motor terminals sit at the supply and the motor brakes. While it is high, the direction input selects one diagonal of the bridge. Both inputs are synchronised through two flops before they are decoded.

Each leg has its own interlock with a down-counter. When the wanted side of a leg changes, the switch that was on is released at once, and the other switch is enabled only after a dead time given as a number of clock cycles. A wanted-state change during the countdown restarts it, so a pulse shorter than the dead time leaves both switches of that leg off. A bypass input removes the dead time and drives the gates straight from the decoded inputs. Per-switch shutdown masks from the fault logic and a global disable force gates off without delay. Direction pulses with the pulse input held high (fast decay) go through the same interlock.

Top module: `hb_gate_sequencer`

## Requirements
- R1: While reset is high and in the cycles after it, before the dead time has counted out, all four gates are off (bypass low). After a reset release the high switches come on at the fifth clock edge when the dead time is 5.
- R2: With the pulse input low, gate_en is 4'b0101: high switch 1 (bit 0) and high switch 2 (bit 2) on, both low switches off.
- R3: With the pulse input high and direction 0, gate_en is 4'b1001 (high 1 and low 2); with direction 1 it is 4'b0110 (high 2 and low 1).
- R4: The two switches of one leg (bits 0/1, bits 2/3) are never on together. After an input change, the switch being released goes off on the third clock edge, and its partner comes on dt clock edges after that.
- R5: A change of a leg's wanted side during its countdown reloads the count, so a toggle shorter than the dead time keeps both switches of that leg off until a full dead time has passed after the last change.
- R6: With the pulse input held high, each direction change sends both legs through their interlocks; the bridge passes through 4'b0000 for the dead time between diagonals.
- R7: With dt_bypass high, the gates follow the decode of the synchronised inputs with no counter delay (new pattern visible after the second clock edge). With dt_bypass low and a dead time of 0, a change shows after the third edge with no off cycle.
- R8: disable_all high forces gate_en to 4'b0000 in the same cycle. When it falls, the gates return to the interlock's pattern at once, with no new dead time.
- R9: shut_mask bit i (bit 0 high 1, bit 1 low 1, bit 2 high 2, bit 3 low 2) forces gate_en bit i off in the same cycle, and the other gates are unaffected.
- R10: The dead time is taken from dt_cycles while reset is high. Later changes of dt_cycles are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches dt_cycles |
| pwm_in | input | 1 | Pulse-width command, asynchronous |
| dir_in | input | 1 | Direction command, asynchronous |
| dt_cycles | input | DT_W (10) | Dead time in clock cycles, taken during reset |
| dt_bypass | input | 1 | Removes dead time and interlock delay |
| disable_all | input | 1 | Forces all gates off |
| shut_mask | input | 4 | Per-switch fault shutdown, bit order as gate_en |
| gate_en | output | 4 | Gate enables: [0] high 1, [1] low 1, [2] high 2, [3] low 2 |

## Verification
On every cycle, the assertions check that the two switches of each leg are never on together, that the disable and every mask bit hold their gates off, and that, with a nonzero dead time and no bypass, no switch rises straight after its partner was on. The exact dead-time length, the restart on short glitches, the braking and diagonal patterns, the bypass latency and the dead time latched at reset can only be shown by the bench. It compares every cycle against its own behavioural model and also checks hand-counted edges at the critical points.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int LEGS  = 2;
    localparam int GATES = 2 * LEGS;

    // gate vector layout: per leg, high switch at even index, low at odd
    localparam int G_HS1 = 0;
    localparam int G_LS1 = 1;
    localparam int G_HS2 = 2;
    localparam int G_LS2 = 3;

    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } side_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drv_t;

    typedef struct packed {
        side_e leg2;
        side_e leg1;
    } bridge_want_t;

    // pulse low: both legs high (brake); pulse high: direction picks diagonal
    function automatic bridge_want_t decode_cmd(input logic pwm, input logic dir);
        bridge_want_t w;
        if (!pwm) begin
            w.leg1 = SIDE_HIGH;
            w.leg2 = SIDE_HIGH;
        end else if (!dir) begin
            w.leg1 = SIDE_HIGH;
            w.leg2 = SIDE_LOW;
        end else begin
            w.leg1 = SIDE_LOW;
            w.leg2 = SIDE_HIGH;
        end
        return w;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_leg_ctrl.sv
module hb_leg_ctrl
    import hb_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  side_e           want,
    input  logic [DT_W-1:0] dt_run,
    input  logic [DT_W-1:0] dt_rst,
    input  logic            bypass,
    output leg_drv_t        drv
);
    side_e           tgt;
    logic [DT_W-1:0] cnt;
    logic            settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt <= SIDE_HIGH;
            cnt <= dt_rst;
        end else if (want != tgt) begin
            tgt <= want;
            cnt <= dt_run;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign settled = (cnt == '0);

    always_comb begin
        if (bypass) begin
            drv.hi = (want == SIDE_HIGH);
            drv.lo = (want == SIDE_LOW);
        end else begin
            drv.hi = settled && (tgt == SIDE_HIGH);
            drv.lo = settled && (tgt == SIDE_LOW);
        end
    end
endmodule

// File: rtl/hb_gate_mask.sv
module hb_gate_mask
    import hb_pkg::*;
(
    input  leg_drv_t         drv [LEGS],
    input  logic [GATES-1:0] shut_mask,
    input  logic             disable_all,
    output logic [GATES-1:0] gate_en
);
    logic [GATES-1:0] raw;

    for (genvar g = 0; g < LEGS; g++) begin : g_pack
        assign raw[2*g]   = drv[g].hi;
        assign raw[2*g+1] = drv[g].lo;
    end

    assign gate_en = raw & ~shut_mask & {GATES{~disable_all}};
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hb_pkg::*;
#(
    parameter int DT_W      = 10,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             dir_in,
    input  logic [DT_W-1:0]  dt_cycles,
    input  logic             dt_bypass,
    input  logic             disable_all,
    input  logic [GATES-1:0] shut_mask,
    output logic [GATES-1:0] gate_en
);
    logic [DT_W-1:0] dt_q;
    logic            pwm_s;
    logic            dir_s;
    bridge_want_t    want;
    side_e           want_leg [LEGS];
    leg_drv_t        drv [LEGS];

    always_ff @(posedge clk) begin
        if (rst) dt_q <= dt_cycles;
    end

    hb_sync #(.W(2), .STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dir_in, pwm_in}),
        .q   ({dir_s, pwm_s})
    );

    assign want        = decode_cmd(pwm_s, dir_s);
    assign want_leg[0] = want.leg1;
    assign want_leg[1] = want.leg2;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hb_leg_ctrl #(.DT_W(DT_W)) u_leg (
            .clk    (clk),
            .rst    (rst),
            .want   (want_leg[g]),
            .dt_run (dt_q),
            .dt_rst (dt_cycles),
            .bypass (dt_bypass),
            .drv    (drv[g])
        );
    end

    hb_gate_mask u_mask (
        .drv         (drv),
        .shut_mask   (shut_mask),
        .disable_all (disable_all),
        .gate_en     (gate_en)
    );
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
module hb_gate_sequencer_chk
    import hb_pkg::*;
#(
    parameter int DT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             dt_bypass,
    input logic             disable_all,
    input logic [GATES-1:0] shut_mask,
    input logic [GATES-1:0] gate_en,
    input logic [DT_W-1:0]  dt_q
);
    AST_LEG1_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate_en[G_HS1] && gate_en[G_LS1])) else $error("leg 1 overlap"); // R4

    AST_LEG2_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate_en[G_HS2] && gate_en[G_LS2])) else $error("leg 2 overlap"); // R4

    AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        disable_all |-> (gate_en == '0)) else $error("disable leak"); // R8

    for (genvar i = 0; i < GATES; i++) begin : g_mask
        AST_MASKED_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
            shut_mask[i] |-> !gate_en[i]) else $error("mask leak"); // R9
    end

    for (genvar g = 0; g < LEGS; g++) begin : g_gap
        AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
            (!dt_bypass && !$past(dt_bypass) && dt_q != '0 && $rose(gate_en[2*g]))
            |-> !$past(gate_en[2*g+1])) else $error("no dead time before high"); // R4

        AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
            (!dt_bypass && !$past(dt_bypass) && dt_q != '0 && $rose(gate_en[2*g+1]))
            |-> !$past(gate_en[2*g])) else $error("no dead time before low"); // R4
    end
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk #(.DT_W(DT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dt_bypass   (dt_bypass),
    .disable_all (disable_all),
    .shut_mask   (shut_mask),
    .gate_en     (gate_en),
    .dt_q        (dt_q)
);

// File: tb/hb_gate_sequencer_bench.sv
`timescale 1ns/1ps
module hb_gate_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwm_in, dir_in;
    logic [9:0] dt_cycles;
    logic       dt_bypass, disable_all;
    logic [3:0] shut_mask;
    logic [3:0] gate_en;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    hb_gate_sequencer u_hb_gate_sequencer (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .dir_in(dir_in),
        .dt_cycles(dt_cycles), .dt_bypass(dt_bypass), .disable_all(disable_all),
        .shut_mask(shut_mask), .gate_en(gate_en)
    );

    // ---------------- behavioural reference ----------------
    int pq [$];          // pulse samples in flight through the synchroniser
    int dq [$];
    int side [2];        // 1 = high wanted/held, 0 = low
    int left [2];        // cycles of dead time still to wait
    int dt_model;

    function automatic int leg_want(int leg, int p, int d);
        if (p == 0) return 1;
        return (leg == 0) ? (d == 0) : (d == 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pq = '{0, 0};
            dq = '{0, 0};
            dt_model = dt_cycles;
            for (int l = 0; l < 2; l++) begin side[l] = 1; left[l] = dt_cycles; end
        end else begin
            for (int l = 0; l < 2; l++) begin
                int w;
                w = leg_want(l, pq[0], dq[0]);
                if (w != side[l]) begin side[l] = w; left[l] = dt_model; end
                else if (left[l] > 0) left[l] = left[l] - 1;
            end
            void'(pq.pop_front()); pq.push_back(int'(pwm_in));
            void'(dq.pop_front()); dq.push_back(int'(dir_in));
        end
    end

    function automatic logic [3:0] model_gates();
        logic [3:0] e;
        for (int l = 0; l < 2; l++) begin
            int h;
            if (dt_bypass) begin
                h = leg_want(l, pq[0], dq[0]);
                e[2*l] = (h == 1); e[2*l+1] = (h == 0);
            end else begin
                e[2*l]   = (left[l] == 0) && (side[l] == 1);
                e[2*l+1] = (left[l] == 0) && (side[l] == 0);
            end
        end
        if (disable_all) return 4'b0000;
        return e & ~shut_mask;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0] e;
            e = model_gates();
            checks++;
            if (gate_en !== e) begin
                errors++;
                $display("FAIL %s cycle compare: actual=%b expected=%b at %0t", cur_req, gate_en, e, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input int edges, input logic [3:0] exp, input string req);
        repeat (edges) @(posedge clk);
        @(negedge clk);
        checks++;
        if (gate_en !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, gate_en, exp, $time);
        end
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input int dt, input logic byp);
        @(negedge clk); #1;
        rst = 1'b1; dt_cycles = 10'(dt); dt_bypass = byp;
        pwm_in = 1'b0; dir_in = 1'b0; disable_all = 1'b0; shut_mask = 4'b0000;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        rst = 1'b1; pwm_in = 1'b0; dir_in = 1'b0; dt_cycles = 10'd5;
        dt_bypass = 1'b0; disable_all = 1'b0; shut_mask = 4'b0000;
        idle(3);
        cur_req = "R1";
        chk(0, 4'b0000, "R1 during reset");
        rst = 1'b0;
        chk(4, 4'b0000, "R1 dead time after reset");
        cur_req = "R2";
        chk(1, 4'b0101, "R2 brake on both high switches");

        // diagonal dir=0 with exact dead-time edges
        cur_req = "R4";
        pwm_in = 1'b1; dir_in = 1'b0;
        chk(2, 4'b0101, "R4 unchanged before third edge");
        chk(1, 4'b0001, "R4 released switch off at third edge");
        chk(4, 4'b0001, "R4 partner still waiting");
        chk(1, 4'b1001, "R3 diagonal dir0 after dead time");

        // short glitch on pulse input: leg 2 restarts its count
        cur_req = "R5";
        pwm_in = 1'b0;
        idle(2);
        pwm_in = 1'b1;
        chk(2, 4'b0001, "R5 leg2 off during glitch");
        chk(4, 4'b0001, "R5 count restarted");
        chk(2, 4'b1001, "R5 low2 back after full dead time");

        // fast decay: direction change with pulse high
        cur_req = "R6";
        dir_in = 1'b1;
        chk(3, 4'b0000, "R6 both legs in dead time");
        chk(5, 4'b0110, "R3 diagonal dir1");

        // disable and masks
        cur_req = "R8";
        disable_all = 1'b1;
        chk(0, 4'b0000, "R8 disable forces off");
        disable_all = 1'b0;
        chk(0, 4'b0110, "R8 release without new dead time");
        cur_req = "R9";
        shut_mask = 4'b0010;
        chk(0, 4'b0100, "R9 low1 masked, high2 unaffected");
        shut_mask = 4'b0100;
        chk(0, 4'b0010, "R9 high2 masked, low1 unaffected");
        shut_mask = 4'b0000;
        chk(0, 4'b0110, "R9 mask released");

        // dead time latched at reset
        cur_req = "R10";
        dt_cycles = 10'd20;
        dir_in = 1'b0;
        chk(3, 4'b0000, "R10 dead time running");
        chk(5, 4'b1001, "R10 latched dead time of 5 kept");
        repeat (6) begin
            dir_in = ~dir_in;
            idle(12);
        end

        // bypass with zero dead time
        do_reset(0, 1'b1);
        cur_req = "R7";
        idle(2);
        pwm_in = 1'b1; dir_in = 1'b1;
        chk(1, 4'b0101, "R7 bypass before second edge");
        chk(1, 4'b0110, "R7 bypass after second edge");
        dt_bypass = 1'b0;
        idle(2);
        dir_in = 1'b0;
        chk(2, 4'b0110, "R7 zero dead time before third edge");
        chk(1, 4'b1001, "R7 zero dead time at third edge");
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 5) == 0) pwm_in = ~pwm_in;
            if ($urandom_range(0, 5) == 0) dir_in = ~dir_in;
            dt_bypass = ($urandom_range(0, 40) == 0) ? ~dt_bypass : dt_bypass;
            idle(1);
        end

        // long randomised run with dead time 7
        do_reset(7, 1'b0);
        cur_req = "R4";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 11) == 0) pwm_in = ~pwm_in;
            if ($urandom_range(0, 15) == 0) dir_in = ~dir_in;
            if ($urandom_range(0, 60) == 0) shut_mask = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 80) == 0) disable_all = ~disable_all;
            idle(1);
        end

        finish_run();
    end

endmodule